// File: doc/BRIEF.md
# Card Column Strobe Synchronizer

A punched card reaches the read station at an arbitrary moment relative to the timing disk on the drive shaft. The disk gives two pulses per data column. This block locks the per-column read strobes to those pulses so that every column is read at the same point.

A good-pick pulse marks the card's leading edge. It loads a preset delay counter, which ends with a one-cycle zero marker at the start of the first pseudo-column. During that delay the block counts the count-clock ticks that follow the most recent disk pulse. It stores that count as the card's phase offset when the marker fires. After the marker, every second disk pulse starts a replay counter. When the replay counter equals the stored offset, the block emits four strobes in a fixed order, one on each phase of the four-phase clock. Counting columns is left to a neighbouring block.

Top module: `card_strobe_sync`

## Requirements
- R1: `phase` is one-hot, with bit0 = A, bit1 = B, bit2 = C and bit3 = D. It rotates A, B, C, D with one phase per clock cycle. A count tick is a cycle in which phase A is active.
- R2: `good_pick` loads the preset counter with `PRESET_INIT`, whose all-ones value is the terminal count. Counting then advances one step per tick. `zero_mark` is high for exactly one cycle: the cycle after tick number 2^W - `PRESET_INIT` following the good-pick cycle.
- R3: After the zero marker, no further marker occurs and offset capture stops until the next `good_pick`.
- R4: The stored offset is the number of ticks strictly between the latest disk pulse before the zero tick and the zero tick itself. Every disk pulse before the marker restarts this count, so the shortest interval is kept. With no such pulse the offset is 0.
- R5: A disk pulse in the same cycle as the zero tick is not used for the offset. It counts as the first pulse after the marker.
- R6: Disk pulses from the marker onward are numbered 1, 2, 3 and so on. Each even-numbered pulse restarts the replay counter, which matches on tick number offset+1 after that pulse. Odd-numbered pulses have no effect.
- R7: A match in cycle m produces the C strobe in cycle m+2, then D in m+3, A in m+4 and B in m+5. The B strobe ends the compare cycle. The output bits are `strobe[0]` = C, `strobe[1]` = D, `strobe[2]` = A and `strobe[3]` = B, with at most one high at a time.
- R8: `rst` clears every counter and the stored offset. After reset, disk pulses produce neither a marker nor strobes until a `good_pick` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| phase | input | 4 | One-hot four-phase clock (A, B, C, D) |
| disk_pulse | input | 1 | One-cycle timing-disk pulse |
| good_pick | input | 1 | One-cycle leading-edge pulse |
| zero_mark | output | 1 | Start of the first pseudo-column |
| strobe | output | 4 | Column strobes: bit0 = C, bit1 = D, bit2 = A, bit3 = B |

## Verification
The collision that matters is a disk pulse that lands in the same cycle as the zero tick. In that cycle, offset capture and the counting of post-marker pulses both want the pulse. The bench provokes this by sweeping the first pulse position over every residue of the pulse period, for three periods, so that some cards put a pulse on a phase-A cycle exactly at the zero tick. It then judges every cycle's strobe vector against expectations built from the arithmetic of R4 to R7. A shifted parity or a wrong captured offset moves all strobes of that card.

// File: rtl/card_strobe_sync.sv
module card_strobe_sync #(
  parameter int W           = 7,
  parameter int PRESET_INIT = 120
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] phase,
  input  logic       disk_pulse,
  input  logic       good_pick,
  output logic       zero_mark,
  output logic [3:0] strobe
);
  localparam logic [W-1:0] TERM = {W{1'b1}};
  localparam logic [W-1:0] INIT = W'(PRESET_INIT);

  logic [W-1:0] pre_cnt, off_cnt, off_store, rep_cnt;
  logic         pre_run, off_run, armed_done, odd_seen, rep_run;
  logic [2:0]   stage;

  wire tick       = phase[0];
  wire zero_ev    = pre_run & tick & (pre_cnt == TERM);
  wire post_pulse = disk_pulse & (armed_done | zero_ev);
  wire rep_start  = post_pulse & odd_seen;
  wire match      = rep_run & tick & (rep_cnt == off_store) & ~rep_start;

  assign strobe[0] = (stage == 3'd1) & phase[2];
  assign strobe[1] = (stage == 3'd2) & phase[3];
  assign strobe[2] = (stage == 3'd3) & phase[0];
  assign strobe[3] = (stage == 3'd4) & phase[1];

  always_ff @(posedge clk) begin
    if (rst || good_pick) begin
      pre_cnt    <= rst ? '0 : INIT;
      pre_run    <= ~rst;
      off_cnt    <= '0;
      off_run    <= 1'b0;
      off_store  <= '0;
      armed_done <= 1'b0;
      odd_seen   <= 1'b0;
      rep_cnt    <= '0;
      rep_run    <= 1'b0;
      stage      <= 3'd0;
      zero_mark  <= 1'b0;
    end else begin
      zero_mark <= zero_ev;

      if (zero_ev) pre_run <= 1'b0;
      else if (pre_run && tick) pre_cnt <= pre_cnt + 1'b1;

      if (zero_ev) begin
        off_store  <= off_cnt;
        off_run    <= 1'b0;
        armed_done <= 1'b1;
      end else if (pre_run && disk_pulse) begin
        off_cnt <= '0;
        off_run <= 1'b1;
      end else if (off_run && tick) begin
        off_cnt <= off_cnt + 1'b1;
      end

      if (post_pulse) odd_seen <= ~odd_seen;

      if (rep_start) begin
        rep_cnt <= '0;
        rep_run <= 1'b1;
      end else if (match) begin
        rep_run <= 1'b0;
      end else if (rep_run && tick) begin
        rep_cnt <= rep_cnt + 1'b1;
      end

      if (match) stage <= 3'd1;
      else if (strobe != 4'd0) stage <= (stage == 3'd4) ? 3'd0 : stage + 3'd1;
    end
  end

  a_r1_phase_onehot: assert property (@(posedge clk) disable iff (rst) $onehot(phase));
  a_r2_no_marker_after_pick: assert property (@(posedge clk) disable iff (rst) good_pick |=> !zero_mark);
  a_r3_marker_single: assert property (@(posedge clk) disable iff (rst) zero_mark |=> !zero_mark);
  a_r6_strobe_needs_marker: assert property (@(posedge clk) disable iff (rst) (strobe != 4'd0) |-> armed_done);
  a_r7_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(strobe));
  a_r7_c_then_d: assert property (@(posedge clk) disable iff (rst) (strobe[0] && !good_pick) |=> strobe[1]);
  a_r7_d_then_a: assert property (@(posedge clk) disable iff (rst) (strobe[1] && !good_pick) |=> strobe[2]);
  a_r7_a_then_b: assert property (@(posedge clk) disable iff (rst) (strobe[2] && !good_pick) |=> strobe[3]);
endmodule

// File: tb/test_card_strobe_sync.sv
module test_card_strobe_sync;
  localparam int W = 7;
  localparam int INIT = 120;
  localparam int TICKS = (1 << W) - INIT;
  localparam int NW = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] phase = 4'b0001;
  logic disk_pulse = 1'b0;
  logic good_pick = 1'b0;
  logic zero_mark;
  logic [3:0] strobe;
  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  card_strobe_sync #(.W(W), .PRESET_INIT(INIT)) i_card_strobe_sync (
    .clk(clk), .rst(rst), .phase(phase), .disk_pulse(disk_pulse),
    .good_pick(good_pick), .zero_mark(zero_mark), .strobe(strobe));

  always #4 clk = ~clk;

  always @(negedge clk) begin
    cyc = cyc + 1;
    phase = 4'b0001 << cyc[1:0];
  end

  function automatic bit pulse_at(int c, int g, int d, int p, int lim);
    return (c >= g + d) && (((c - g - d) % p) == 0) && (c < lim);
  endfunction

  task automatic check(string tag, int c, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s cycle=%0d actual=%b expected=%b", tag, c, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); #1;
    rst = 1'b1; good_pick = 1'b0; disk_pulse = 1'b0;
    @(negedge clk); #1;
    @(negedge clk); #1;
    rst = 1'b0;
  endtask

  // R8: pulses without a good pick yield nothing
  task automatic idle_pulses(int n, int p);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      good_pick = 1'b0;
      disk_pulse = (i % p) == 3;
      #1;
      check("R8 idle", cyc, {zero_mark, strobe}, 5'b0);
    end
  endtask

  task automatic run_card(int d, int p, int nw);
    logic [3:0] es [0:255];
    logic ez [0:255];
    int c0, g, z, t, n, plast, off, j, m, lim;
    @(negedge clk); #1;
    c0 = cyc; g = c0 + 1; lim = c0 + nw - 40;
    for (int i = 0; i < 256; i++) begin es[i] = 4'b0; ez[i] = 1'b0; end
    t = g; n = 0;
    while (n < TICKS) begin t++; if (t % 4 == 0) n++; end
    z = t;
    if (z + 1 - c0 < nw) ez[z + 1 - c0] = 1'b1;
    plast = -1;
    for (int c = g; c < z; c++) if (pulse_at(c, g, d, p, lim)) plast = c;
    off = 0;
    if (plast >= 0) for (int c = plast + 1; c < z; c++) if (c % 4 == 0) off++;
    j = 0;
    for (int q = z; q < c0 + nw; q++) begin
      if (pulse_at(q, g, d, p, lim)) begin
        j++;
        if (j % 2 == 0) begin
          m = q; n = 0;
          while (n < off + 1) begin m++; if (m % 4 == 0) n++; end
          for (int s = 0; s < 4; s++) if (m + 2 + s - c0 < nw) es[m + 2 + s - c0][s] = 1'b1;
        end
      end
    end
    for (int k = 0; k < nw; k++) begin
      if (k > 0) begin @(negedge clk); #1; end
      good_pick = (cyc == g);
      disk_pulse = pulse_at(cyc, g, d, p, lim);
      #1;
      check("R1 R2 R3 zero_mark", cyc, {4'b0, zero_mark}, {4'b0, ez[k]});
      check("R4 R5 R6 R7 strobe", cyc, {1'b0, strobe}, {1'b0, es[k]});
    end
    good_pick = 1'b0; disk_pulse = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R8 reset state", cyc, {zero_mark, strobe}, 5'b0);
    rst = 1'b0;
    idle_pulses(40, 8);
    for (int pi = 0; pi < 3; pi++)
      for (int d = 1; d <= 20; d++)
        run_card(d, 12 + 4 * pi, NW);
    run_card(50, 16, NW);
    run_card(5, 16, 45);
    do_reset();
    idle_pulses(80, 8);
    run_card(3, 20, NW);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule